// File: doc/BRIEF.md
# Condition Register Update Unit

This block holds a 32-bit condition register split into eight 4-bit fields and performs every operation that writes it. A signed or unsigned compare of two operands, or of an operand against a 16-bit immediate, produces a less/greater/equal flag group plus the summary-overflow bit, written into one selected field. Eight boolean functions combine any two register bits into a third. A field-to-field copy moves one nibble. A masked move loads chosen nibbles from a general register. A read operation captures the whole register on a read port.

Bit numbering is big-endian: logical bit n of the register sits at vector position 31-n, so field 0 occupies positions 31..28 and field 7 occupies positions 3..0. One operation is accepted per cycle when `op_valid` is high. The result appears on the outputs after the next rising clock edge. A synchronous reset clears the register and the read port to zero.

Top module: `cr_update_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `cr_q` and `rd_data` to zero.
- R2: Op code 0 (signed compare) writes the nibble {LT,GT,EQ,SO} into field `tgt_field` at positions 31-4*f down to 28-4*f. LT is the most significant bit of the nibble. LT, GT and EQ follow the two's-complement order of `opnd_a` against `opnd_b`, and exactly one of the three is set. The other fields are unchanged.
- R3: Op code 1 (unsigned compare) writes the same nibble format, using unsigned magnitude order of `opnd_a` against `opnd_b`.
- R4: Op code 2 compares `opnd_a` signed against `opnd_b[15:0]` sign-extended to 32 bits. Op code 3 compares `opnd_a` unsigned against `opnd_b[15:0]` zero-extended to 32 bits.
- R5: The least significant bit (SO) of every compare nibble equals `so_in`.
- R6: Op codes 4 to 11 perform AND, OR, NAND, XOR, NOR, equivalence, a AND NOT b, and a OR NOT b, in that order. The operand a is the register bit at position 31-`bit_a` and the operand b is the bit at position 31-`bit_b`. The result is written to position 31-`bit_t`, and no other bit changes.
- R7: Op code 12 copies field `src_field` into field `tgt_field`. The other fields are unchanged, and copying a field onto itself leaves the register unchanged.
- R8: Op code 13 sets bit i of `fld_mask` to select positions 4i+3..4i. The new register is (`opnd_a` & mask) | (old & ~mask), so a zero mask changes nothing.
- R9: Op code 14 loads `rd_data` with the register value at the next edge and leaves `cr_q` unchanged.
- R10: With `op_valid` low, or with op code 15, neither output changes. No operation other than op code 14 changes `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Accept the operation this cycle |
| op_code | input | 4 | Operation selector (see requirements) |
| opnd_a | input | 32 | First compare operand; source for the masked move |
| opnd_b | input | 32 | Second compare operand; low 16 bits are the immediate |
| tgt_field | input | 3 | Destination field index |
| src_field | input | 3 | Source field index for the copy |
| bit_a | input | 5 | First source bit index for bit operations |
| bit_b | input | 5 | Second source bit index for bit operations |
| bit_t | input | 5 | Destination bit index for bit operations |
| fld_mask | input | 8 | Nibble enables for the masked move |
| so_in | input | 1 | Summary-overflow bit stored by compares |
| cr_q | output | 32 | Current condition register |
| rd_data | output | 32 | Register value captured by the last read |

## Verification
Compares are exercised with operands that are negative, equal, and at the sign boundary (0x80000000 against 0x7FFFFFFF). At that boundary a signed compare gives LT and an unsigned compare gives GT, which separates the two orders. An immediate of 0x8000 and one of 0xFFFF show whether sign or zero extension was applied. The bit operations are run from a register state in which the chosen source bits have distinct values, so each boolean function gives a result that differs from its neighbours. Source, target and equal indices show that the big-endian positions are used. Masked moves with zero, split and full masks, and copies onto the same and a different field, show which nibbles are touched.

// File: rtl/cr_pkg.sv
package cr_pkg;

    typedef enum logic [3:0] {
        OP_CMP_S   = 4'd0,
        OP_CMP_U   = 4'd1,
        OP_CMP_SI  = 4'd2,
        OP_CMP_UI  = 4'd3,
        OP_B_AND   = 4'd4,
        OP_B_OR    = 4'd5,
        OP_B_NAND  = 4'd6,
        OP_B_XOR   = 4'd7,
        OP_B_NOR   = 4'd8,
        OP_B_EQV   = 4'd9,
        OP_B_ANDC  = 4'd10,
        OP_B_ORC   = 4'd11,
        OP_FCOPY   = 4'd12,
        OP_MMOVE   = 4'd13,
        OP_READ    = 4'd14,
        OP_RSVD    = 4'd15
    } cr_op_e;

    // positions inside a compare nibble
    localparam int NIB_LT = 3;
    localparam int NIB_GT = 2;
    localparam int NIB_EQ = 1;
    localparam int NIB_SO = 0;

    localparam int IMM_W = 16;

endpackage

// File: rtl/cr_cmp_nibble.sv
module cr_cmp_nibble #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int FLD_W  = 4
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs_raw,
    input  logic              is_signed,
    input  logic              use_imm,
    input  logic              so,
    output logic [FLD_W-1:0]  nib
);
    import cr_pkg::*;

    logic [DATA_W-1:0] rhs;
    logic              lt;
    logic              gt;

    always_comb begin
        if (use_imm) begin
            if (is_signed) begin
                rhs = {{(DATA_W-IMM_W){rhs_raw[IMM_W-1]}}, rhs_raw[IMM_W-1:0]};
            end else begin
                rhs = {{(DATA_W-IMM_W){1'b0}}, rhs_raw[IMM_W-1:0]};
            end
        end else begin
            rhs = rhs_raw;
        end
        if (is_signed) begin
            lt = $signed(lhs) < $signed(rhs);
            gt = $signed(lhs) > $signed(rhs);
        end else begin
            lt = lhs < rhs;
            gt = lhs > rhs;
        end
        nib         = '0;
        nib[NIB_LT] = lt;
        nib[NIB_GT] = gt;
        nib[NIB_EQ] = !lt && !gt;
        nib[NIB_SO] = so;
    end

endmodule

// File: rtl/cr_bit_logic.sv
module cr_bit_logic #(
    parameter int CR_W  = 32,
    localparam int BIT_W = $clog2(CR_W)
) (
    input  logic [CR_W-1:0]  cr,
    input  logic [BIT_W-1:0] idx_a,
    input  logic [BIT_W-1:0] idx_b,
    input  logic [2:0]       fn,
    output logic             res
);
    logic [BIT_W-1:0] pos_a;
    logic [BIT_W-1:0] pos_b;
    logic             a;
    logic             b;

    always_comb begin
        pos_a = BIT_W'(CR_W - 1) - idx_a;
        pos_b = BIT_W'(CR_W - 1) - idx_b;
        a     = cr[pos_a];
        b     = cr[pos_b];
        unique case (fn)
            3'd0:    res = a & b;
            3'd1:    res = a | b;
            3'd2:    res = !(a & b);
            3'd3:    res = a ^ b;
            3'd4:    res = !(a | b);
            3'd5:    res = !(a ^ b);
            3'd6:    res = a & !b;
            default: res = a | !b;
        endcase
    end

endmodule

// File: rtl/cr_nibble_mask.sv
module cr_nibble_mask #(
    parameter int N_FIELDS = 8,
    parameter int FLD_W    = 4,
    localparam int CR_W    = N_FIELDS * FLD_W
) (
    input  logic [N_FIELDS-1:0] sel,
    output logic [CR_W-1:0]     mask
);
    for (genvar i = 0; i < N_FIELDS; i++) begin : g_nib
        assign mask[FLD_W*i +: FLD_W] = {FLD_W{sel[i]}};
    end

endmodule

// File: rtl/cr_update_unit.sv
module cr_update_unit #(
    parameter int N_FIELDS = 8,
    parameter int FLD_W    = 4,
    localparam int CR_W    = N_FIELDS * FLD_W,
    localparam int IDX_W   = $clog2(N_FIELDS),
    localparam int BIT_W   = $clog2(CR_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [3:0]          op_code,
    input  logic [CR_W-1:0]     opnd_a,
    input  logic [CR_W-1:0]     opnd_b,
    input  logic [IDX_W-1:0]    tgt_field,
    input  logic [IDX_W-1:0]    src_field,
    input  logic [BIT_W-1:0]    bit_a,
    input  logic [BIT_W-1:0]    bit_b,
    input  logic [BIT_W-1:0]    bit_t,
    input  logic [N_FIELDS-1:0] fld_mask,
    input  logic                so_in,
    output logic [CR_W-1:0]     cr_q,
    output logic [CR_W-1:0]     rd_data
);
    import cr_pkg::*;

    typedef struct packed {
        logic [CR_W-1:0] cr;
        logic [CR_W-1:0] rd;
    } cr_state_t;

    cr_state_t st_d;
    cr_state_t st_q;

    logic [FLD_W-1:0] cmp_nib;
    logic             cmp_signed;
    logic             cmp_imm;
    logic             bit_res;
    logic [CR_W-1:0]  move_mask;

    // field f lives at the high end for f == 0 (big-endian numbering)
    function automatic logic [BIT_W-1:0] field_lsb(input logic [IDX_W-1:0] f);
        return BIT_W'(FLD_W * (N_FIELDS - 1 - int'(f)));
    endfunction

    assign cmp_signed = (op_code == OP_CMP_S) || (op_code == OP_CMP_SI);
    assign cmp_imm    = (op_code == OP_CMP_SI) || (op_code == OP_CMP_UI);

    cr_cmp_nibble #(
        .DATA_W (CR_W),
        .IMM_W  (IMM_W),
        .FLD_W  (FLD_W)
    ) u_cmp (
        .lhs       (opnd_a),
        .rhs_raw   (opnd_b),
        .is_signed (cmp_signed),
        .use_imm   (cmp_imm),
        .so        (so_in),
        .nib       (cmp_nib)
    );

    cr_bit_logic #(
        .CR_W (CR_W)
    ) u_bit (
        .cr    (st_q.cr),
        .idx_a (bit_a),
        .idx_b (bit_b),
        .fn    (3'(op_code - 4'(OP_B_AND))),
        .res   (bit_res)
    );

    cr_nibble_mask #(
        .N_FIELDS (N_FIELDS),
        .FLD_W    (FLD_W)
    ) u_mask (
        .sel  (fld_mask),
        .mask (move_mask)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            unique case (op_code)
                OP_CMP_S, OP_CMP_U, OP_CMP_SI, OP_CMP_UI: begin
                    st_d.cr[field_lsb(tgt_field) +: FLD_W] = cmp_nib;
                end
                OP_B_AND, OP_B_OR, OP_B_NAND, OP_B_XOR,
                OP_B_NOR, OP_B_EQV, OP_B_ANDC, OP_B_ORC: begin
                    st_d.cr[BIT_W'(CR_W - 1) - bit_t] = bit_res;
                end
                OP_FCOPY: begin
                    st_d.cr[field_lsb(tgt_field) +: FLD_W] =
                        st_q.cr[field_lsb(src_field) +: FLD_W];
                end
                OP_MMOVE: begin
                    st_d.cr = (opnd_a & move_mask) | (st_q.cr & ~move_mask);
                end
                OP_READ: begin
                    st_d.rd = st_q.cr;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cr_q    = st_q.cr;
    assign rd_data = st_q.rd;

endmodule

// File: rtl/cr_update_unit_chk.sv
module cr_update_unit_chk #(
    parameter int N_FIELDS = 8,
    parameter int FLD_W    = 4,
    localparam int CR_W    = N_FIELDS * FLD_W,
    localparam int IDX_W   = $clog2(N_FIELDS),
    localparam int BIT_W   = $clog2(CR_W)
) (
    input logic                clk,
    input logic                rst,
    input logic                op_valid,
    input logic [3:0]          op_code,
    input logic [IDX_W-1:0]    tgt_field,
    input logic [N_FIELDS-1:0] fld_mask,
    input logic                so_in,
    input logic [CR_W-1:0]     cr_q,
    input logic [CR_W-1:0]     rd_data
);

    function automatic logic [FLD_W-1:0] nib_of(input logic [CR_W-1:0] v,
                                                input logic [IDX_W-1:0] f);
        logic [CR_W-1:0] sh;
        sh = v >> (FLD_W * (N_FIELDS - 1 - int'(f)));
        return sh[FLD_W-1:0];
    endfunction

    function automatic logic [CR_W-1:0] widen(input logic [N_FIELDS-1:0] m);
        logic [CR_W-1:0] r;
        r = '0;
        for (int i = 0; i < N_FIELDS; i++) begin
            if (m[i]) r = r | (CR_W'({FLD_W{1'b1}}) << (FLD_W * i));
        end
        return r;
    endfunction

    logic is_cmp;
    logic is_bop;
    assign is_cmp = op_valid && (op_code <= 4'd3);
    assign is_bop = op_valid && (op_code >= 4'd4) && (op_code <= 4'd11);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cr_q == '0) && (rd_data == '0));

    p_cmp_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        is_cmp |=> $countones(nib_of(cr_q, $past(tgt_field)) >> 1) == 1);

    p_cmp_so_r5: assert property (@(posedge clk) disable iff (rst)
        is_cmp |=> nib_of(cr_q, $past(tgt_field)) == ((nib_of(cr_q, $past(tgt_field)) >> 1) << 1 | FLD_W'($past(so_in))));

    p_bitop_single_r6: assert property (@(posedge clk) disable iff (rst)
        is_bop |=> $countones(cr_q ^ $past(cr_q)) <= 1);

    p_mmove_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd13) |=>
            ((cr_q ^ $past(cr_q)) & ~widen($past(fld_mask))) == '0);

    p_read_capture_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd14) |=> (rd_data == $past(cr_q)) && $stable(cr_q));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op_code == 4'd15) |=> $stable(cr_q) && $stable(rd_data));

    p_rd_only_read_r10: assert property (@(posedge clk) disable iff (rst)
        (op_code != 4'd14) |=> $stable(rd_data));

endmodule

bind cr_update_unit cr_update_unit_chk #(
    .N_FIELDS (N_FIELDS),
    .FLD_W    (FLD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .tgt_field (tgt_field),
    .fld_mask  (fld_mask),
    .so_in     (so_in),
    .cr_q      (cr_q),
    .rd_data   (rd_data)
);

// File: tb/cr_update_unit_test.sv
module cr_update_unit_test;
    import cr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic        valid;
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [2:0]  bf;
        logic [2:0]  bfa;
        logic [4:0]  ba;
        logic [4:0]  bb;
        logic [4:0]  bt;
        logic [7:0]  mask;
        logic        so;
        logic [31:0] exp_cr;
        logic [31:0] exp_rd;
        logic [7:0]  req;
    } vec_t;

    // walked in order from the reset state; each row states the register after it
    localparam vec_t VECS [18] = '{
        // R2 signed: -5 < 3 -> LT in field 0
        '{1'b1, 4'd0,  32'hFFFF_FFFB, 32'd3,        3'd0, 3'd0, 5'd0,  5'd0,  5'd0,  8'h00, 1'b0, 32'h8000_0000, 32'h0, 8'd2},
        // R3 unsigned: large > 3 -> GT, SO=1 in field 1 (R5)
        '{1'b1, 4'd1,  32'hFFFF_FFFB, 32'd3,        3'd1, 3'd0, 5'd0,  5'd0,  5'd0,  8'h00, 1'b1, 32'h8500_0000, 32'h0, 8'd3},
        // R4 signed immediate 0xFFFF == -1 -> EQ in field 2
        '{1'b1, 4'd2,  32'hFFFF_FFFF, 32'h0000_FFFF, 3'd2, 3'd0, 5'd0,  5'd0,  5'd0,  8'h00, 1'b0, 32'h8520_0000, 32'h0, 8'd4},
        // R4 unsigned immediate 65535 < all-ones -> GT in field 3
        '{1'b1, 4'd3,  32'hFFFF_FFFF, 32'h0000_FFFF, 3'd3, 3'd0, 5'd0,  5'd0,  5'd0,  8'h00, 1'b0, 32'h8524_0000, 32'h0, 8'd4},
        // R5 equal with SO into field 7
        '{1'b1, 4'd0,  32'd7,        32'd7,        3'd7, 3'd0, 5'd0,  5'd0,  5'd0,  8'h00, 1'b1, 32'h8524_0003, 32'h0, 8'd5},
        // R6 AND 1,1 -> bit 16
        '{1'b1, 4'd4,  32'h0,        32'h0,        3'd0, 3'd0, 5'd0,  5'd5,  5'd16, 8'h00, 1'b0, 32'h8524_8003, 32'h0, 8'd6},
        // R6 NOR 1,0 -> 0 into bit 0
        '{1'b1, 4'd8,  32'h0,        32'h0,        3'd0, 3'd0, 5'd0,  5'd1,  5'd0,  8'h00, 1'b0, 32'h0524_8003, 32'h0, 8'd6},
        // R6 EQV 0,0 -> 1 into bit 20
        '{1'b1, 4'd9,  32'h0,        32'h0,        3'd0, 3'd0, 5'd1,  5'd2,  5'd20, 8'h00, 1'b0, 32'h0524_8803, 32'h0, 8'd6},
        // R6 ANDC 1,1 -> 0 into bit 31
        '{1'b1, 4'd10, 32'h0,        32'h0,        3'd0, 3'd0, 5'd16, 5'd31, 5'd31, 8'h00, 1'b0, 32'h0524_8802, 32'h0, 8'd6},
        // R6 ORC 0,0 -> 1 into bit 27
        '{1'b1, 4'd11, 32'h0,        32'h0,        3'd0, 3'd0, 5'd3,  5'd3,  5'd27, 8'h00, 1'b0, 32'h0524_8812, 32'h0, 8'd6},
        // R6 XOR 0,1 -> 1 into bit 4
        '{1'b1, 4'd7,  32'h0,        32'h0,        3'd0, 3'd0, 5'd4,  5'd7,  5'd4,  8'h00, 1'b0, 32'h0D24_8812, 32'h0, 8'd6},
        // R6 NAND 1,1 -> 0 into bit 7
        '{1'b1, 4'd6,  32'h0,        32'h0,        3'd0, 3'd0, 5'd4,  5'd7,  5'd7,  8'h00, 1'b0, 32'h0C24_8812, 32'h0, 8'd6},
        // R6 OR 0,0 -> 0 into bit 10
        '{1'b1, 4'd5,  32'h0,        32'h0,        3'd0, 3'd0, 5'd9,  5'd8,  5'd10, 8'h00, 1'b0, 32'h0C04_8812, 32'h0, 8'd6},
        // R7 copy field 1 to field 3
        '{1'b1, 4'd12, 32'h0,        32'h0,        3'd3, 3'd1, 5'd0,  5'd0,  5'd0,  8'h00, 1'b0, 32'h0C0C_8812, 32'h0, 8'd7},
        // R8 mask bits 7 and 0
        '{1'b1, 4'd13, 32'h1234_5678, 32'h0,       3'd0, 3'd0, 5'd0,  5'd0,  5'd0,  8'h81, 1'b0, 32'h1C0C_8818, 32'h0, 8'd8},
        // R9 read
        '{1'b1, 4'd14, 32'h0,        32'h0,        3'd0, 3'd0, 5'd0,  5'd0,  5'd0,  8'h00, 1'b0, 32'h1C0C_8818, 32'h1C0C_8818, 8'd9},
        // R10 reserved code
        '{1'b1, 4'd15, 32'hFFFF_FFFF, 32'h0,       3'd0, 3'd0, 5'd0,  5'd0,  5'd0,  8'hFF, 1'b1, 32'h1C0C_8818, 32'h1C0C_8818, 8'd10},
        // R10 strobe low
        '{1'b0, 4'd13, 32'hFFFF_FFFF, 32'h0,       3'd0, 3'd0, 5'd0,  5'd0,  5'd0,  8'hFF, 1'b0, 32'h1C0C_8818, 32'h1C0C_8818, 8'd10}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [2:0]  tgt_field = '0;
    logic [2:0]  src_field = '0;
    logic [4:0]  bit_a = '0;
    logic [4:0]  bit_b = '0;
    logic [4:0]  bit_t = '0;
    logic [7:0]  fld_mask = '0;
    logic        so_in = 1'b0;
    logic [31:0] cr_q;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cr_update_unit uut (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .tgt_field (tgt_field),
        .src_field (src_field),
        .bit_a     (bit_a),
        .bit_b     (bit_b),
        .bit_t     (bit_t),
        .fld_mask  (fld_mask),
        .so_in     (so_in),
        .cr_q      (cr_q),
        .rd_data   (rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        op_valid  = v.valid;
        op_code   = v.op;
        opnd_a    = v.a;
        opnd_b    = v.b;
        tgt_field = v.bf;
        src_field = v.bfa;
        bit_a     = v.ba;
        bit_b     = v.bb;
        bit_t     = v.bt;
        fld_mask  = v.mask;
        so_in     = v.so;
        @(negedge clk);
        op_valid  = 1'b0;
        check($sformatf("R%0d cr", v.req), cr_q, v.exp_cr);
        check($sformatf("R%0d rd", v.req), rd_data, v.exp_rd);
    endtask

    function automatic vec_t mk(input logic [3:0] op, input logic [31:0] a,
                                input logic [31:0] b, input logic [2:0] bf,
                                input logic [2:0] bfa, input logic [4:0] bi,
                                input logic [7:0] m, input logic so,
                                input logic [31:0] ecr, input logic [31:0] erd,
                                input int rq);
        return '{1'b1, op, a, b, bf, bfa, bi, bi, bi, m, so, ecr, erd, 8'(rq)};
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, WATCHDOG);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset cr", cr_q, 32'h0);
        check("R1 reset rd", rd_data, 32'h0);

        for (int i = 0; i < 18; i++) apply(VECS[i]);

        // R2 / R3 sign boundary: signed LT, unsigned GT in field 0
        apply(mk(4'd0, 32'h8000_0000, 32'h7FFF_FFFF, 3'd0, 3'd0, 5'd0, 8'h00, 1'b0,
                 32'h8C0C_8818, 32'h1C0C_8818, 2));
        apply(mk(4'd1, 32'h8000_0000, 32'h7FFF_FFFF, 3'd0, 3'd0, 5'd0, 8'h00, 1'b0,
                 32'h4C0C_8818, 32'h1C0C_8818, 3));
        // R4 immediate 0x8000: signed -32768 vs zero-extended 32768, field 4
        apply(mk(4'd2, 32'h0, 32'h0000_8000, 3'd4, 3'd0, 5'd0, 8'h00, 1'b0,
                 32'h4C0C_4818, 32'h1C0C_8818, 4));
        apply(mk(4'd3, 32'h0, 32'h0000_8000, 3'd4, 3'd0, 5'd0, 8'h00, 1'b0,
                 32'h4C0C_8818, 32'h1C0C_8818, 4));
        // R8 zero mask, then full mask
        apply(mk(4'd13, 32'hFFFF_FFFF, 32'h0, 3'd0, 3'd0, 5'd0, 8'h00, 1'b0,
                 32'h4C0C_8818, 32'h1C0C_8818, 8));
        apply(mk(4'd13, 32'hDEAD_BEEF, 32'h0, 3'd0, 3'd0, 5'd0, 8'hFF, 1'b0,
                 32'hDEAD_BEEF, 32'h1C0C_8818, 8));
        // R7 self copy, then field 7 into field 0
        apply(mk(4'd12, 32'h0, 32'h0, 3'd2, 3'd2, 5'd0, 8'h00, 1'b0,
                 32'hDEAD_BEEF, 32'h1C0C_8818, 7));
        apply(mk(4'd12, 32'h0, 32'h0, 3'd0, 3'd7, 5'd0, 8'h00, 1'b0,
                 32'hFEAD_BEEF, 32'h1C0C_8818, 7));
        // R6 XOR with all three indices 31
        apply(mk(4'd7, 32'h0, 32'h0, 3'd0, 3'd0, 5'd31, 8'h00, 1'b0,
                 32'hFEAD_BEEE, 32'h1C0C_8818, 6));
        // R9 read, then R10 compare leaves rd alone (R5 SO=1)
        apply(mk(4'd14, 32'h0, 32'h0, 3'd0, 3'd0, 5'd0, 8'h00, 1'b0,
                 32'hFEAD_BEEE, 32'hFEAD_BEEE, 9));
        apply(mk(4'd0, 32'd1, 32'd2, 3'd7, 3'd0, 5'd0, 8'h00, 1'b1,
                 32'hFEAD_BEE9, 32'hFEAD_BEEE, 10));

        // R1 reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid reset cr", cr_q, 32'h0);
        check("R1 mid reset rd", rd_data, 32'h0);

        summary();
    end

endmodule